// File: doc/BRIEF.md
# Flash Block Program/Erase/Verify Sequencer

This block is the local controller for one block of a flash array. A dispatcher hands it read, program and erase commands, which it holds in a small in-order queue. Each command starts with a look at the block's two-bit status register. A block that has failed refuses every command. A write-inhibited block refuses program and erase but still serves reads. Status is checked before the sense amplifiers or the high-voltage pump are ever enabled.

A read enables sensing and waits for the sense-complete input. It then captures the sensed word and reports completion on the next edge. Program and erase turn on the high-voltage pump and alternate a fixed-width high-voltage pulse with a verify handshake until verify reports a pass. The number of pulse/verify rounds is capped by a programmable budget. If the budget runs out, the block is marked failed for good, and every later command is refused. A successful program can optionally lock the block against further writing, which covers a boot region that may be written only once. When a command finishes, the controller pulls the next queued command at once.

Top module: `flash_blk_seq`

## Requirements
- R1: After a synchronous reset the block is idle: `busy`, `done`, `pump_en`, `hv_pulse`, `verify_req` and `sense_en` are low, `stat_q` is 2'b00 and `cmd_ready` is high.
- R2: A command issued while the failed flag (`stat_q[0]`) is set completes with code REJECT and enables neither the pump, the pulse nor the sense amplifiers.
- R3: While the write-inhibit flag (`stat_q[1]`) is set, program (op 2'b10) and erase (op 2'b11) complete with REJECT and no pulse, and read (op 2'b01) is still carried out.
- R4: A read holds `sense_en` high until `sense_done`. On the edge after `sense_done` it presents the sampled `sense_data` on `rd_data` together with a one-cycle `done` carrying code PASS. The pump stays off throughout.
- R5: Program and erase keep `pump_en` high across every pulse and verify. Each pulse holds `hv_pulse` high for exactly PULSE_CYC cycles and is followed by a `verify_req` held until `verify_done`. The first passing verify ends the command with PASS, and the number of pulses equals the number of verifies made.
- R6: When `loop_limit` verifies in a row fail, the command ends with code FAIL after exactly `loop_limit` pulses, and the failed flag is set on the same edge as `done`. A `loop_limit` of 0 selects the default budget of 16.
- R7: The failed flag stays set until reset, and a status write (`stat_we`) cannot clear it.
- R8: A rejected command leaves `stat_q` unchanged.
- R9: Commands presented with `cmd_valid` while `cmd_ready` is high are queued, up to QDEPTH entries, and executed in arrival order. `cmd_ready` is low while the queue is full.
- R10: With LOCK_ON_PROG set (the default), a program that ends in PASS sets the write-inhibit flag on the same edge as `done`. Erase and read never set it.
- R11: Each completion raises `done` for one cycle, with `done_op` equal to the command's op and `done_code` equal to 2'b01 PASS, 2'b10 FAIL or 2'b11 REJECT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present from dispatcher |
| cmd_op | input | 2 | Operation: 01 read, 10 program, 11 erase |
| cmd_ready | output | 1 | Queue has room |
| stat_we | input | 1 | Write the write-inhibit flag |
| stat_wr_inh | input | 1 | Value for the write-inhibit flag |
| stat_q | output | 2 | Block status: bit 0 failed, bit 1 write-inhibit |
| loop_limit | input | LW | Pulse/verify budget, 0 selects DEF_LOOPS |
| pump_en | output | 1 | High-voltage pump enable |
| hv_pulse | output | 1 | High-voltage pulse gate |
| hv_erase | output | 1 | Pump is set for erase, not program |
| verify_req | output | 1 | Request a verify |
| verify_done | input | 1 | Verify result valid |
| verify_pass | input | 1 | Verify succeeded |
| sense_en | output | 1 | Sense amplifier enable |
| sense_done | input | 1 | Sensing complete |
| sense_data | input | DW | Sensed word |
| rd_data | output | DW | Captured read word |
| done | output | 1 | One-cycle completion strobe |
| done_op | output | 2 | Op of the completed command |
| done_code | output | 2 | Completion code |
| busy | output | 1 | A command is in progress |

## Verification
A wrong iteration count or a wrong pulse timer shows up directly as a pulse count or a pulse width at the high-voltage outputs that differs from expectation, and it is visible within the command where it happens. A lost or late failed flag stays hidden until the next command on the block. That command then runs the pump or sense path instead of returning REJECT, so the bench always follows a failure with further commands and status writes. A queue pointer fault shows up as completions whose op or code come back out of order. The queue test mixes reads, a locking program and an erase so that any reordering changes the codes that come out.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_PASS = 2'b01,
    RES_FAIL = 2'b10,
    RES_REJ  = 2'b11
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_SENSE,
    S_PULSE,
    S_VERIFY
  } seq_state_e;
endpackage

// File: rtl/fseq_cmd_fifo.sv
module fseq_cmd_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fseq_blk_status.sv
module fseq_blk_status (
  input  logic clk,
  input  logic rst,
  input  logic sw_we,
  input  logic sw_inh,
  input  logic set_fail,
  input  logic set_inh,
  output logic failed,
  output logic inhibit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      failed  <= 1'b0;
      inhibit <= 1'b0;
    end else begin
      if (set_fail) failed <= 1'b1;
      if (sw_we)    inhibit <= sw_inh;
      if (set_inh)  inhibit <= 1'b1;
    end
  end
endmodule

// File: rtl/fseq_pv_budget.sv
module fseq_pv_budget #(
  parameter int LW        = 8,
  parameter int DEF_LOOPS = 16,
  parameter int PULSE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] limit,
  input  logic          step,
  input  logic          pulse_act,
  output logic          last_loop,
  output logic          pulse_last
);
  localparam int PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  logic [LW-1:0] loops, budget_m1;
  logic [PW-1:0] ptmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      loops     <= '0;
      budget_m1 <= LW'(DEF_LOOPS - 1);
      ptmr      <= '0;
    end else begin
      if (load) begin
        loops     <= '0;
        budget_m1 <= (limit == '0) ? LW'(DEF_LOOPS - 1) : limit - 1'b1;
      end else if (step) begin
        loops <= loops + 1'b1;
      end
      ptmr <= pulse_act ? ptmr + 1'b1 : '0;
    end
  end

  assign last_loop  = (loops == budget_m1);
  assign pulse_last = pulse_act && (ptmr == PW'(PULSE_CYC - 1));
endmodule

// File: rtl/flash_blk_seq.sv
module flash_blk_seq
  import flash_seq_pkg::*;
#(
  parameter int DW           = 8,
  parameter int LW           = 8,
  parameter int QDEPTH       = 4,
  parameter int PULSE_CYC    = 4,
  parameter int DEF_LOOPS    = 16,
  parameter bit LOCK_ON_PROG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  output logic          cmd_ready,
  input  logic          stat_we,
  input  logic          stat_wr_inh,
  output logic [1:0]    stat_q,
  input  logic [LW-1:0] loop_limit,
  output logic          pump_en,
  output logic          hv_pulse,
  output logic          hv_erase,
  output logic          verify_req,
  input  logic          verify_done,
  input  logic          verify_pass,
  output logic          sense_en,
  input  logic          sense_done,
  input  logic [DW-1:0] sense_data,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic [1:0]    done_op,
  output logic [1:0]    done_code,
  output logic          busy
);
  seq_state_e st;
  op_e        op_q;
  logic [1:0] q_dout;
  logic       q_full, q_empty, q_pop;
  logic       blk_failed, blk_inh;
  logic       last_loop, pulse_last;
  logic       v_fail_step, v_ok, set_fail, set_inh;
  logic       refuse;

  fseq_cmd_fifo #(.DEPTH(QDEPTH), .W(2)) queue_i (
    .clk(clk), .rst(rst), .push(cmd_valid), .din(cmd_op), .pop(q_pop),
    .dout(q_dout), .full(q_full), .empty(q_empty)
  );

  fseq_blk_status status_i (
    .clk(clk), .rst(rst), .sw_we(stat_we), .sw_inh(stat_wr_inh),
    .set_fail(set_fail), .set_inh(set_inh),
    .failed(blk_failed), .inhibit(blk_inh)
  );

  fseq_pv_budget #(.LW(LW), .DEF_LOOPS(DEF_LOOPS), .PULSE_CYC(PULSE_CYC)) budget_i (
    .clk(clk), .rst(rst), .load(st == S_CHECK), .limit(loop_limit),
    .step(v_fail_step), .pulse_act(st == S_PULSE),
    .last_loop(last_loop), .pulse_last(pulse_last)
  );

  always_comb begin
    q_pop       = (st == S_IDLE) && !q_empty;
    v_ok        = (st == S_VERIFY) && verify_done && verify_pass;
    v_fail_step = (st == S_VERIFY) && verify_done && !verify_pass;
    set_fail    = v_fail_step && last_loop;
    set_inh     = LOCK_ON_PROG && v_ok && (op_q == OP_PROG);
    refuse      = blk_failed || (op_q == OP_NONE) || (blk_inh && (op_q != OP_READ));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      op_q      <= OP_NONE;
      done      <= 1'b0;
      done_op   <= 2'b00;
      done_code <= RES_NONE;
      rd_data   <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (!q_empty) begin
            op_q <= op_e'(q_dout);
            st   <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (refuse) begin
            done      <= 1'b1;
            done_op   <= op_q;
            done_code <= RES_REJ;
            st        <= S_IDLE;
          end else if (op_q == OP_READ) begin
            st <= S_SENSE;
          end else begin
            st <= S_PULSE;
          end
        end
        S_SENSE: begin
          if (sense_done) begin
            rd_data   <= sense_data;
            done      <= 1'b1;
            done_op   <= op_q;
            done_code <= RES_PASS;
            st        <= S_IDLE;
          end
        end
        S_PULSE: begin
          if (pulse_last) st <= S_VERIFY;
        end
        S_VERIFY: begin
          if (verify_done) begin
            if (verify_pass || last_loop) begin
              done      <= 1'b1;
              done_op   <= op_q;
              done_code <= verify_pass ? RES_PASS : RES_FAIL;
              st        <= S_IDLE;
            end else begin
              st <= S_PULSE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready  = !q_full;
  assign stat_q     = {blk_inh, blk_failed};
  assign pump_en    = (st == S_PULSE) || (st == S_VERIFY);
  assign hv_pulse   = (st == S_PULSE);
  assign hv_erase   = pump_en && (op_q == OP_ERASE);
  assign verify_req = (st == S_VERIFY);
  assign sense_en   = (st == S_SENSE);
  assign busy       = (st != S_IDLE);
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pump_en,
  input logic       hv_pulse,
  input logic       verify_req,
  input logic       sense_en,
  input logic [1:0] stat_q,
  input logic       done,
  input logic [1:0] done_code
);
  // R5
  pulse_in_pump_chk: assert property (@(posedge clk) disable iff (rst)
    hv_pulse |-> pump_en);

  // R5
  verify_in_pump_chk: assert property (@(posedge clk) disable iff (rst)
    verify_req |-> (pump_en && !hv_pulse));

  // R4
  sense_no_pump_chk: assert property (@(posedge clk) disable iff (rst)
    sense_en |-> !pump_en);

  // R2
  pump_good_blk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_en) |-> !$past(stat_q[0]));

  // R3
  pump_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_en) |-> !$past(stat_q[1]));

  // R6
  fail_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[0]) |-> (done && done_code == 2'b10));

  // R7
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stat_q[0] |=> stat_q[0]);

  // R11
  done_code_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_code != 2'b00));
endmodule

bind flash_blk_seq fseq_chk chk_i (
  .clk(clk), .rst(rst), .pump_en(pump_en), .hv_pulse(hv_pulse),
  .verify_req(verify_req), .sense_en(sense_en), .stat_q(stat_q),
  .done(done), .done_code(done_code)
);

// File: tb/flash_blk_seq_tb_top.sv
`timescale 1ns/1ps
module flash_blk_seq_tb_top;
  localparam int DW   = 8;
  localparam int LW   = 8;
  localparam int PCYC = 3;
  localparam int NVEC = 10;

  // op, preset inhibit, failing verifies, limit, exp code, exp pulses, exp stat
  localparam logic [25:0] VEC [NVEC] = '{
    {2'd1, 1'b0, 5'd0,  8'd4, 2'd1, 6'd0,  2'b00},  // R4 read
    {2'd2, 1'b0, 5'd0,  8'd4, 2'd1, 6'd1,  2'b10},  // R5 R10 program locks
    {2'd3, 1'b0, 5'd2,  8'd4, 2'd1, 6'd3,  2'b00},  // R5 erase, no lock
    {2'd3, 1'b0, 5'd9,  8'd4, 2'd2, 6'd4,  2'b01},  // R6 budget out
    {2'd2, 1'b0, 5'd3,  8'd4, 2'd1, 6'd4,  2'b10},  // R6 pass on last round
    {2'd2, 1'b1, 5'd0,  8'd4, 2'd3, 6'd0,  2'b10},  // R3 R8 program refused
    {2'd3, 1'b1, 5'd0,  8'd4, 2'd3, 6'd0,  2'b10},  // R3 R8 erase refused
    {2'd1, 1'b1, 5'd0,  8'd4, 2'd1, 6'd0,  2'b10},  // R3 read allowed
    {2'd3, 1'b0, 5'd31, 8'd0, 2'd2, 6'd16, 2'b01},  // R6 default budget
    {2'd2, 1'b0, 5'd20, 8'd1, 2'd2, 6'd1,  2'b01}   // R6 budget of one
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic          cmd_ready;
  logic          stat_we = 1'b0;
  logic          stat_wr_inh = 1'b0;
  logic [1:0]    stat_q;
  logic [LW-1:0] loop_limit = '0;
  logic          pump_en, hv_pulse, hv_erase, verify_req;
  logic          verify_done = 1'b0;
  logic          verify_pass = 1'b0;
  logic          sense_en;
  logic          sense_done = 1'b0;
  logic [DW-1:0] sense_data = '0;
  logic [DW-1:0] rd_data;
  logic          done;
  logic [1:0]    done_op, done_code;
  logic          busy;

  int checks = 0;
  int errors = 0;
  int nfail = 0;
  int va = 0;
  int pcnt = 0;
  int scnt = 0;
  int run = 0;
  int lastrun = 0;
  logic [DW-1:0] sdat = 8'hC3;

  always #4 clk = ~clk;

  flash_blk_seq #(.DW(DW), .LW(LW), .QDEPTH(4), .PULSE_CYC(PCYC),
                  .DEF_LOOPS(16), .LOCK_ON_PROG(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ready(cmd_ready), .stat_we(stat_we), .stat_wr_inh(stat_wr_inh),
    .stat_q(stat_q), .loop_limit(loop_limit), .pump_en(pump_en),
    .hv_pulse(hv_pulse), .hv_erase(hv_erase), .verify_req(verify_req),
    .verify_done(verify_done), .verify_pass(verify_pass), .sense_en(sense_en),
    .sense_done(sense_done), .sense_data(sense_data), .rd_data(rd_data),
    .done(done), .done_op(done_op), .done_code(done_code), .busy(busy)
  );

  // verify responder: answers two cycles into each request
  initial begin
    logic vwait;
    vwait = 1'b0;
    forever begin
      @(negedge clk);
      if (verify_done) begin
        verify_done = 1'b0;
        vwait = 1'b0;
      end else if (verify_req) begin
        if (vwait) begin
          verify_done = 1'b1;
          verify_pass = (va >= nfail);
          va++;
        end else vwait = 1'b1;
      end else vwait = 1'b0;
    end
  end

  // sense responder
  initial begin
    logic swait;
    swait = 1'b0;
    forever begin
      @(negedge clk);
      if (sense_done) begin
        sense_done = 1'b0;
        swait = 1'b0;
      end else if (sense_en) begin
        if (swait) begin
          sense_done = 1'b1;
          sense_data = sdat;
        end else swait = 1'b1;
      end else swait = 1'b0;
    end
  end

  // pulse and sense monitor
  initial begin
    logic pprev, sprev;
    pprev = 1'b0;
    sprev = 1'b0;
    forever begin
      @(negedge clk);
      if (hv_pulse && !pprev) pcnt++;
      if (sense_en && !sprev) scnt++;
      if (hv_pulse) run++;
      else if (pprev) begin
        lastrun = run;
        run = 0;
      end
      pprev = hv_pulse;
      sprev = sense_en;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [1:0] op);
    cmd_valid = 1'b1;
    cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic write_inh(input logic v);
    stat_we = 1'b1;
    stat_wr_inh = v;
    @(negedge clk);
    stat_we = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!done) check(req, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 pump/pulse/verify/sense",
          int'({pump_en, hv_pulse, verify_req, sense_en}), 0);
    check("R1 stat_q", int'(stat_q), 0);
    check("R1 cmd_ready", int'(cmd_ready), 1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] vop, vcode, vstat;
      logic       vinh;
      logic [4:0] vnf;
      logic [7:0] vlim;
      logic [5:0] vpul;
      {vop, vinh, vnf, vlim, vcode, vpul, vstat} = VEC[i];
      do_reset();
      if (vinh) write_inh(1'b1);
      nfail = int'(vnf);
      va = 0;
      pcnt = 0;
      scnt = 0;
      lastrun = 0;
      loop_limit = vlim;
      sdat = 8'h30 + 8'(i);
      push(vop);
      wait_done($sformatf("R11 vec%0d timeout", i));
      check($sformatf("R11 vec%0d done_op", i), int'(done_op), int'(vop));
      check($sformatf("R5 R6 R3 vec%0d done_code", i), int'(done_code), int'(vcode));
      check($sformatf("R5 R6 vec%0d pulses", i), pcnt, int'(vpul));
      check($sformatf("R8 R10 R6 vec%0d stat_q", i), int'(stat_q), int'(vstat));
      if (vpul != 0)
        check($sformatf("R5 vec%0d pulse width", i), lastrun, PCYC);
      if (vop == 2'd1) begin
        check($sformatf("R4 vec%0d rd_data", i), int'(rd_data), int'(sdat));
        check($sformatf("R4 vec%0d sense count", i), scnt, 1);
      end
      @(negedge clk);
      check($sformatf("R11 vec%0d done one cycle", i), int'(done), 0);
    end

    // R2 R7 R8: failed block refuses everything and stays failed
    do_reset();
    nfail = 30;
    va = 0;
    loop_limit = 8'd2;
    push(2'd2);
    wait_done("R6 fail setup");
    check("R6 failed flag", int'(stat_q), 2'b01);
    pcnt = 0;
    scnt = 0;
    nfail = 0;
    push(2'd1);
    wait_done("R2 read timeout");
    check("R2 read on failed block", int'(done_code), 3);
    check("R2 no sense on failed block", scnt, 0);
    write_inh(1'b0);
    check("R7 failed not cleared by write", int'(stat_q[0]), 1);
    push(2'd3);
    wait_done("R2 erase timeout");
    check("R2 erase on failed block", int'(done_code), 3);
    check("R2 no pulse on failed block", pcnt, 0);
    check("R8 stat after reject", int'(stat_q), 2'b01);
    write_inh(1'b1);
    write_inh(1'b0);
    check("R7 failed after inhibit toggle", int'(stat_q), 2'b01);

    // R3: software can release the inhibit flag again
    do_reset();
    write_inh(1'b1);
    check("R3 inhibit written", int'(stat_q), 2'b10);
    write_inh(1'b0);
    nfail = 0;
    va = 0;
    pcnt = 0;
    loop_limit = 8'd4;
    push(2'd3);
    wait_done("R3 erase after release");
    check("R3 erase after release", int'(done_code), 1);
    check("R3 erase pulse after release", pcnt, 1);

    // R9 queue order and fullness
    do_reset();
    nfail = 1;
    va = 0;
    loop_limit = 8'd4;
    push(2'd3);
    push(2'd1);
    push(2'd2);
    push(2'd3);
    push(2'd1);
    check("R9 cmd_ready low when full", int'(cmd_ready), 0);
    begin
      logic [1:0] exp_op [5];
      logic [1:0] exp_cd [5];
      exp_op = '{2'd3, 2'd1, 2'd2, 2'd3, 2'd1};
      exp_cd = '{2'd1, 2'd1, 2'd1, 2'd3, 2'd1};
      for (int k = 0; k < 5; k++) begin
        if (k == 2) va = 0;
        wait_done($sformatf("R9 entry%0d timeout", k));
        check($sformatf("R9 entry%0d op", k), int'(done_op), int'(exp_op[k]));
        check($sformatf("R9 entry%0d code", k), int'(done_code), int'(exp_cd[k]));
        @(negedge clk);
      end
    end
    check("R9 cmd_ready after drain", int'(cmd_ready), 1);
    check("R10 stat after queued program", int'(stat_q), 2'b10);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule